// File: doc/BRIEF.md
# Nibble Accumulator Arithmetic Execute Unit

This block carries out the arithmetic and logic instruction group of a small 4-bit controller core. It owns a 4-bit accumulator and a 1-bit carry flag. In any cycle where the valid strobe is high, it takes an 8-bit opcode and the data-memory nibble at the current pointer. It updates its state on the next rising clock edge.

The unit does not branch. It reports arithmetic outcomes through a registered skip request, which the sequencer uses to suppress the instruction that follows. Only the carry-in add writes the carry flag from the sum. The immediate add skips on overflow but leaves the flag alone. The plain add neither skips nor touches the flag.

Top module: `nac_exec_unit`

## Requirements
- R1: Asserting the synchronous reset clears the accumulator, the carry flag and the skip output at the next rising edge.
- R2: Opcode 0x30 computes accumulator + carry + memory nibble. The low 4 bits go into the accumulator and bit 4 goes into the carry flag. Skip is raised exactly when that bit 4 is 1.
- R3: Opcode 0x31 writes the low 4 bits of accumulator + memory nibble into the accumulator. It leaves the carry flag unchanged and never raises skip.
- R4: Opcodes 0x51 to 0x5F add the low opcode nibble (1 to 15) to the accumulator. Skip is raised when the 4-bit sum overflows, and the carry flag is left unchanged.
- R5: Opcode 0x00 loads zero into the accumulator. Opcode 0x40 loads the bitwise inverse of the accumulator. Neither changes the carry or raises skip.
- R6: Opcode 0x02 loads accumulator XOR memory nibble into the accumulator, with carry unchanged and no skip.
- R7: Opcode 0x32 clears the carry flag and opcode 0x22 sets it. The accumulator is unchanged and there is no skip.
- R8: Opcode 0x44, and every opcode not listed in R2 to R7 (including 0x50), leaves the accumulator and carry unchanged and gives no skip.
- R9: While the valid strobe is low, the accumulator and carry hold and skip is 0 at the next edge.
- R10: Skip is registered. It is high for the single cycle after an accepted skipping instruction, and falls on the next edge unless that cycle also accepts a skipping instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Opcode and nibble are presented this cycle |
| opcode | input | 8 | Instruction byte |
| mem_nib | input | 4 | Data memory nibble at the current pointer |
| acc | output | 4 | Accumulator |
| carry | output | 1 | Carry flag |
| skip | output | 1 | Suppress-next-instruction request |

## Verification
The carry-in add is driven through every combination of accumulator, carry and memory nibble, so the bench separates the results that produce a carry-out from those that do not, and the ones where the carry-in decides overflow. The immediate add is run for every immediate and every accumulator value, with the flag preset both ways; this exposes any write to the carry or a skip decision made from the wrong sum. Random full-byte opcodes mixed with idle cycles show whether undefined encodings and low-valid cycles alter state. Back-to-back skipping instructions, and a skipping instruction followed by a non-skipping one, check the one-cycle pulse shape.

// File: rtl/nac_pkg.sv
package nac_pkg;

    localparam int NIB_W = 4;
    localparam int OPC_W = 8;
    localparam int HALF_W = OPC_W / 2;

    typedef logic [NIB_W-1:0] nib_t;
    typedef logic [OPC_W-1:0] opc_t;

    localparam opc_t OPC_ADDC  = 8'h30;
    localparam opc_t OPC_ADD   = 8'h31;
    localparam opc_t OPC_CLRA  = 8'h00;
    localparam opc_t OPC_CPL   = 8'h40;
    localparam opc_t OPC_NOP   = 8'h44;
    localparam opc_t OPC_CLRC  = 8'h32;
    localparam opc_t OPC_SETC  = 8'h22;
    localparam opc_t OPC_XOR   = 8'h02;
    localparam logic [HALF_W-1:0] ADDI_HI = 4'h5;

    typedef enum logic [3:0] {
        K_NONE,
        K_ADDC,
        K_ADD,
        K_ADDI,
        K_CLR,
        K_CPL,
        K_XOR,
        K_CLRC,
        K_SETC
    } kind_e;

    typedef struct packed {
        kind_e kind;
        nib_t  imm;
    } dec_t;

    typedef struct packed {
        nib_t acc;
        logic carry;
        logic skip;
    } res_t;

    function automatic logic is_addi(input opc_t op);
        return (op[OPC_W-1:HALF_W] == ADDI_HI) && (op[HALF_W-1:0] != '0);
    endfunction

endpackage

// File: rtl/nac_decode.sv
module nac_decode
    import nac_pkg::*;
(
    input  opc_t opcode,
    output dec_t dec
);
    always_comb begin
        dec.imm  = opcode[NIB_W-1:0];
        dec.kind = K_NONE;
        if (is_addi(opcode)) begin
            dec.kind = K_ADDI;
        end else begin
            unique case (opcode)
                OPC_ADDC: dec.kind = K_ADDC;
                OPC_ADD:  dec.kind = K_ADD;
                OPC_CLRA: dec.kind = K_CLR;
                OPC_CPL:  dec.kind = K_CPL;
                OPC_XOR:  dec.kind = K_XOR;
                OPC_CLRC: dec.kind = K_CLRC;
                OPC_SETC: dec.kind = K_SETC;
                default:  dec.kind = K_NONE;
            endcase
        end
    end
endmodule

// File: rtl/nac_ripple_add.sv
module nac_ripple_add #(
    parameter int W = 4
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         ci,
    output logic [W-1:0] sum,
    output logic         co
);
    logic [W:0] cc;
    assign cc[0] = ci;

    for (genvar i = 0; i < W; i++) begin : g_bit
        assign sum[i]  = a[i] ^ b[i] ^ cc[i];
        assign cc[i+1] = (a[i] & b[i]) | (cc[i] & (a[i] ^ b[i]));
    end

    assign co = cc[W];
endmodule

// File: rtl/nac_alu.sv
module nac_alu
    import nac_pkg::*;
(
    input  nib_t acc_q,
    input  logic carry_q,
    input  nib_t mem_nib,
    input  dec_t dec,
    output res_t res
);
    nib_t add_b;
    logic add_ci;
    nib_t add_sum;
    logic add_co;

    assign add_b  = (dec.kind == K_ADDI) ? dec.imm : mem_nib;
    assign add_ci = (dec.kind == K_ADDC) ? carry_q : 1'b0;

    nac_ripple_add #(.W(NIB_W)) u_add (
        .a   (acc_q),
        .b   (add_b),
        .ci  (add_ci),
        .sum (add_sum),
        .co  (add_co)
    );

    always_comb begin
        res.acc   = acc_q;
        res.carry = carry_q;
        res.skip  = 1'b0;
        unique case (dec.kind)
            K_ADDC: begin
                res.acc   = add_sum;
                res.carry = add_co;
                res.skip  = add_co;
            end
            K_ADD:  res.acc = add_sum;
            K_ADDI: begin
                res.acc  = add_sum;
                res.skip = add_co;
            end
            K_CLR:  res.acc   = '0;
            K_CPL:  res.acc   = ~acc_q;
            K_XOR:  res.acc   = acc_q ^ mem_nib;
            K_CLRC: res.carry = 1'b0;
            K_SETC: res.carry = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/nac_state.sv
module nac_state
    import nac_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic take,
    input  res_t nxt,
    output nib_t acc_q,
    output logic carry_q,
    output logic skip_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q   <= '0;
            carry_q <= 1'b0;
            skip_q  <= 1'b0;
        end else if (take) begin
            acc_q   <= nxt.acc;
            carry_q <= nxt.carry;
            skip_q  <= nxt.skip;
        end else begin
            skip_q  <= 1'b0;
        end
    end

    a_r9_idle_hold: assert property (@(posedge clk) disable iff (rst)
        !take |=> $stable(acc_q) && $stable(carry_q) && !skip_q);

    a_r10_skip_from_take: assert property (@(posedge clk) disable iff (rst)
        skip_q |-> $past(take));
endmodule

// File: rtl/nac_exec_unit.sv
module nac_exec_unit
    import nac_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       op_valid,
    input  logic [7:0] opcode,
    input  logic [3:0] mem_nib,
    output logic [3:0] acc,
    output logic       carry,
    output logic       skip
);
    dec_t dec;
    res_t nxt;

    nac_decode u_dec (
        .opcode (opcode),
        .dec    (dec)
    );

    nac_alu u_alu (
        .acc_q   (acc),
        .carry_q (carry),
        .mem_nib (mem_nib),
        .dec     (dec),
        .res     (nxt)
    );

    nac_state u_st (
        .clk     (clk),
        .rst     (rst),
        .take    (op_valid),
        .nxt     (nxt),
        .acc_q   (acc),
        .carry_q (carry),
        .skip_q  (skip)
    );

    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> acc == 4'h0 && !carry && !skip);

    a_r3_add_keeps_carry: assert property (@(posedge clk) disable iff (rst)
        op_valid && opcode == 8'h31 |=> !skip && carry == $past(carry));

    a_r4_addi_keeps_carry: assert property (@(posedge clk) disable iff (rst)
        op_valid && opcode[7:4] == 4'h5 && opcode[3:0] != 4'h0 |=> carry == $past(carry));

    a_r5_clear_acc: assert property (@(posedge clk) disable iff (rst)
        op_valid && opcode == 8'h00 |=> acc == 4'h0 && !skip);

    a_r7_set_carry: assert property (@(posedge clk) disable iff (rst)
        op_valid && opcode == 8'h22 |=> carry && acc == $past(acc) && !skip);

    a_r8_nop_holds: assert property (@(posedge clk) disable iff (rst)
        op_valid && (opcode == 8'h44 || opcode == 8'h50) |=> $stable(acc) && $stable(carry) && !skip);
endmodule

// File: tb/tb_nac_exec_unit.sv
module tb_nac_exec_unit;
    localparam int CLK_PERIOD = 10;
    localparam int WDOG_CYC = 100000;

    typedef struct {
        logic [3:0] acc;
        logic       c;
        logic       s;
        string      tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       op_valid = 1'b0;
    logic [7:0] opcode = 8'h00;
    logic [3:0] mem_nib = 4'h0;
    logic [3:0] acc;
    logic       carry;
    logic       skip;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    logic [3:0] m_acc = 4'h0;
    logic       m_c = 1'b0;
    exp_t q[$];

    nac_exec_unit dut (
        .clk(clk), .rst(rst), .op_valid(op_valid), .opcode(opcode),
        .mem_nib(mem_nib), .acc(acc), .carry(carry), .skip(skip)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic push(input logic sk, input string tag);
        exp_t e;
        e.acc = m_acc; e.c = m_c; e.s = sk; e.tag = tag;
        q.push_back(e);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; op_valid = 1'b0;
        m_acc = 4'h0; m_c = 1'b0;
        push(1'b0, "R1");
    endtask

    task automatic step(input logic v, input logic [7:0] op, input logic [3:0] m, input string tag);
        logic [4:0] t;
        logic sk;
        @(negedge clk);
        rst = 1'b0; op_valid = v; opcode = op; mem_nib = m;
        sk = 1'b0;
        if (v) begin
            if (op[7:4] == 4'h5 && op[3:0] != 4'h0) begin
                t = {1'b0, m_acc} + {1'b0, op[3:0]};
                m_acc = t[3:0]; sk = t[4];
            end else begin
                case (op)
                    8'h30: begin
                        t = {1'b0, m_acc} + {1'b0, m} + {4'b0, m_c};
                        m_acc = t[3:0]; m_c = t[4]; sk = t[4];
                    end
                    8'h31: begin
                        t = {1'b0, m_acc} + {1'b0, m};
                        m_acc = t[3:0];
                    end
                    8'h00: m_acc = 4'h0;
                    8'h40: m_acc = ~m_acc;
                    8'h02: m_acc = m_acc ^ m;
                    8'h32: m_c = 1'b0;
                    8'h22: m_c = 1'b1;
                    default: ;
                endcase
            end
        end
        push(sk, tag);
    endtask

    task automatic load(input logic [3:0] a, input logic c);
        step(1'b1, 8'h00, 4'h0, "R5");
        step(1'b1, 8'h31, a, "R3");
        step(1'b1, c ? 8'h22 : 8'h32, 4'h0, "R7");
    endtask

    initial begin
        exp_t e;
        forever begin
            @(posedge clk);
            #1;
            if (q.size() > 0) begin
                e = q.pop_front();
                checks++;
                if (acc !== e.acc || carry !== e.c || skip !== e.s) begin
                    errors++;
                    $display("FAIL %s: acc=%h carry=%b skip=%b expected acc=%h carry=%b skip=%b",
                             e.tag, acc, carry, skip, e.acc, e.c, e.s);
                end
            end
        end
    end

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > WDOG_CYC) begin
                checks++; errors++;
                $display("FAIL watchdog: cycles=%0d expected below %0d", cyc, WDOG_CYC);
                $display("CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        do_reset();
        do_reset();
        // R2: full sweep of carry-in add
        for (int a = 0; a < 16; a++)
            for (int c = 0; c < 2; c++)
                for (int m = 0; m < 16; m++) begin
                    load(4'(a), c[0]);
                    step(1'b1, 8'h30, 4'(m), "R2");
                end
        // R4: every immediate with every accumulator, flag preset both ways
        for (int a = 0; a < 16; a++)
            for (int y = 1; y < 16; y++)
                for (int c = 0; c < 2; c++) begin
                    load(4'(a), c[0]);
                    step(1'b1, {4'h5, 4'(y)}, 4'hF, "R4");
                end
        // R5 / R6 / R3 with varied patterns
        for (int a = 0; a < 16; a++) begin
            load(4'(a), a[0]);
            step(1'b1, 8'h40, 4'h0, "R5");
            step(1'b1, 8'h02, 4'(a * 7 + 3), "R6");
            step(1'b1, 8'h31, 4'(15 - a), "R3");
            step(1'b1, 8'h44, 4'hA, "R8");
            step(1'b1, 8'h50, 4'h5, "R8");
        end
        // R10: back-to-back skipping, then a non-skipping op
        load(4'hF, 1'b1);
        step(1'b1, 8'h30, 4'h1, "R10");
        step(1'b1, 8'h5F, 4'h0, "R10");
        step(1'b1, 8'h44, 4'h0, "R10");
        step(1'b1, 8'h5F, 4'h0, "R10");
        step(1'b1, 8'h5F, 4'h0, "R10");
        step(1'b0, 8'h30, 4'hF, "R9");
        // R8 / R9: random bytes mixed with idle cycles
        for (int i = 0; i < 3000; i++) begin
            logic [7:0] op;
            logic [3:0] m;
            logic v;
            op = 8'($urandom);
            m = 4'($urandom);
            v = ($urandom % 4) != 0;
            step(v, op, m, v ? "R8" : "R9");
        end
        // R1: reset from a non-zero state
        load(4'hB, 1'b1);
        step(1'b1, 8'h5F, 4'h0, "R10");
        do_reset();
        step(1'b0, 8'h00, 4'h0, "R9");
        step(1'b1, 8'h00, 4'h0, "R5");
        repeat (3) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule